// File: doc/BRIEF.md
# Level-Sensitive Completion Interrupt Aggregator

This block merges the per-queue "completions waiting" state of a storage controller into a single level-sensitive legacy interrupt line. The completion-posting logic reports each posting with the queue id and that queue's interrupt-enable flag. The block then marks the queue as pending. When the host writes a completion-queue head doorbell and the new head equals that queue's tail, the queue is fully consumed and its pending mark is removed.

The host controls a 32-bit interrupt mask through two register locations. One location sets mask bits and the other clears them. Both locations read back the current mask. The line is a level, not a pulse. It is recomputed from the pending vector and the mask after every event, so it stays high for as long as any unmasked queue remains pending. A message-signalled mode input freezes all of this state while it is high. The message itself is built elsewhere.

The pending vector is also driven out so that the controller's message-signalled path can observe it.

Top module: `qia_top`

## Requirements
- R1: After reset the pending vector is all zero, the mask is all zero, and `irq_pin` is low.
- R2: One clock edge after any event, `irq_pin` is 1 exactly when some pending bit i is set whose mask bit is clear. Mask bit i covers pending bit i for i = 0..31. Pending bits 32..63 have no mask bit and always count.
- R3: A posting (`post_valid`=1, `post_ien`=1, `msi_mode`=0) sets pending bit `post_qid` at the next edge.
- R4: A head doorbell (`db_valid`=1, `db_ien`=1, `msi_mode`=0) clears pending bit `db_qid` at the next edge when `db_head` equals `db_tail`. It leaves that bit unchanged when they differ.
- R5: A posting with `post_ien`=0, or a doorbell with `db_ien`=0, changes neither the pending vector nor the pin.
- R6: While `msi_mode`=1, the pending vector, the mask and `irq_pin` keep their values, whatever the posting, doorbell and register inputs are.
- R7: A register write (`reg_wr`=1) to offset 0x0C ORs `reg_wdata` into the mask. A write to offset 0x10 clears the mask bits where `reg_wdata` is 1. Writes to other offsets have no effect.
- R8: `reg_rdata` shows the current mask, combinationally, when `reg_addr` is 0x0C or 0x10. It reads 0 at any other offset.
- R9: If a posting and a clearing doorbell hit the same queue in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_mode | input | 1 | Message-signalled mode; freezes all state when 1 |
| post_valid | input | 1 | Completion posted this cycle |
| post_qid | input | 6 | Queue id of the posting |
| post_ien | input | 1 | Interrupt-enable flag of the posting queue |
| db_valid | input | 1 | Completion-queue head doorbell write this cycle |
| db_qid | input | 6 | Queue id of the doorbell |
| db_ien | input | 1 | Interrupt-enable flag of the doorbell queue |
| db_head | input | 16 | New head value written by the host |
| db_tail | input | 16 | Current tail of that queue |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 8 | Host register byte offset |
| reg_wdata | input | 32 | Host register write data |
| reg_rdata | output | 32 | Mask readback |
| pend_o | output | 64 | Pending vector |
| irq_pin | output | 1 | Level-sensitive interrupt line |

## Verification
Pending bits, mask bits and the pin all take their new values at the first rising edge after the triggering inputs are presented. The pin is computed from the next-state values, so it never lags the pending vector by an extra cycle. `reg_rdata` follows `reg_addr` within the same cycle. The bench applies every input just after a falling edge. It advances its reference model at the rising edge and compares `irq_pin`, `pend_o` and `reg_rdata` at the following falling edge, where all three are due.

// File: rtl/qia_pkg.sv
package qia_pkg;
  localparam int unsigned NQ_DEF    = 64;
  localparam int unsigned MASKW_DEF = 32;
  localparam int unsigned PTRW_DEF  = 16;

  // widen the mask to the pending width; uncovered bits never mask
  function automatic logic [NQ_DEF-1:0] widen_mask(input logic [MASKW_DEF-1:0] m);
    logic [NQ_DEF-1:0] w;
    w = '0;
    w[MASKW_DEF-1:0] = m;
    return w;
  endfunction

  // line level for a pending vector under a mask
  function automatic logic line_level(input logic [NQ_DEF-1:0] p,
                                      input logic [MASKW_DEF-1:0] m);
    return |(p & ~widen_mask(m));
  endfunction

  // mask update for one host write
  function automatic logic [MASKW_DEF-1:0] mask_next(input logic [MASKW_DEF-1:0] m,
                                                     input logic set_w,
                                                     input logic clr_w,
                                                     input logic [MASKW_DEF-1:0] d);
    logic [MASKW_DEF-1:0] r;
    r = m;
    if (set_w) r = r | d;
    if (clr_w) r = r & ~d;
    return r;
  endfunction
endpackage

// File: rtl/qia_pending.sv
module qia_pending #(
  parameter int unsigned NQ   = qia_pkg::NQ_DEF,
  localparam int unsigned QIDW = $clog2(NQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_ev,
  input  logic [QIDW-1:0] set_qid,
  input  logic            clr_ev,
  input  logic [QIDW-1:0] clr_qid,
  output logic [NQ-1:0]   pend_d,
  output logic [NQ-1:0]   pend_q
);
  for (genvar i = 0; i < NQ; i++) begin : g_bit
    logic set_i, clr_i;
    assign set_i = set_ev && (set_qid == QIDW'(i));
    assign clr_i = clr_ev && (clr_qid == QIDW'(i));
    // a new completion wins over a same-cycle consume
    assign pend_d[i] = set_i | (pend_q[i] & ~clr_i);

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_d[i];
    end
  end
endmodule

// File: rtl/qia_mask_regs.sv
module qia_mask_regs #(
  parameter int unsigned AW      = 8,
  parameter int unsigned MASKW   = qia_pkg::MASKW_DEF,
  parameter logic [AW-1:0] SET_OFS = 8'h0C,
  parameter logic [AW-1:0] CLR_OFS = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [MASKW-1:0] reg_wdata,
  output logic             mset_ev,
  output logic             mclr_ev,
  output logic [MASKW-1:0] mask_d,
  output logic [MASKW-1:0] mask_q,
  output logic [MASKW-1:0] rdata
);
  logic hit_set, hit_clr;
  assign hit_set = (reg_addr == SET_OFS);
  assign hit_clr = (reg_addr == CLR_OFS);

  assign mset_ev = reg_wr && !freeze && hit_set;
  assign mclr_ev = reg_wr && !freeze && hit_clr;
  assign mask_d  = qia_pkg::mask_next(mask_q, mset_ev, mclr_ev, reg_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign rdata = (hit_set || hit_clr) ? mask_q : '0;
endmodule

// File: rtl/qia_pin.sv
module qia_pin #(
  parameter int unsigned NQ    = qia_pkg::NQ_DEF,
  parameter int unsigned MASKW = qia_pkg::MASKW_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic [NQ-1:0]    pend_d,
  input  logic [MASKW-1:0] mask_d,
  output logic             irq_q
);
  logic lvl_d;
  assign lvl_d = qia_pkg::line_level(pend_d, mask_d);

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (!freeze) irq_q <= lvl_d;
  end
endmodule

// File: rtl/qia_top.sv
module qia_top #(
  parameter int unsigned NQ    = qia_pkg::NQ_DEF,
  parameter int unsigned MASKW = qia_pkg::MASKW_DEF,
  parameter int unsigned PTRW  = qia_pkg::PTRW_DEF,
  parameter int unsigned AW    = 8,
  localparam int unsigned QIDW = $clog2(NQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msi_mode,
  input  logic             post_valid,
  input  logic [QIDW-1:0]  post_qid,
  input  logic             post_ien,
  input  logic             db_valid,
  input  logic [QIDW-1:0]  db_qid,
  input  logic             db_ien,
  input  logic [PTRW-1:0]  db_head,
  input  logic [PTRW-1:0]  db_tail,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [MASKW-1:0] reg_wdata,
  output logic [MASKW-1:0] reg_rdata,
  output logic [NQ-1:0]    pend_o,
  output logic             irq_pin
);
  // named internal events
  logic post_hit, clr_hit, mset_hit, mclr_hit;
  logic [NQ-1:0]    pend_d, pend_q;
  logic [MASKW-1:0] mask_d, mask_q;

  assign post_hit = post_valid && post_ien && !msi_mode;
  assign clr_hit  = db_valid && db_ien && !msi_mode && (db_head == db_tail);

  qia_pending #(.NQ(NQ)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_ev(post_hit), .set_qid(post_qid),
    .clr_ev(clr_hit),  .clr_qid(db_qid),
    .pend_d(pend_d), .pend_q(pend_q)
  );

  qia_mask_regs #(.AW(AW), .MASKW(MASKW)) u_mask (
    .clk(clk), .rst_n(rst_n), .freeze(msi_mode),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mset_ev(mset_hit), .mclr_ev(mclr_hit),
    .mask_d(mask_d), .mask_q(mask_q), .rdata(reg_rdata)
  );

  qia_pin #(.NQ(NQ), .MASKW(MASKW)) u_pin (
    .clk(clk), .rst_n(rst_n), .freeze(msi_mode),
    .pend_d(pend_d), .mask_d(mask_d), .irq_q(irq_pin)
  );

  assign pend_o = pend_q;
endmodule

// File: rtl/qia_chk.sv
module qia_chk #(
  parameter int unsigned NQ    = 64,
  parameter int unsigned MASKW = 32,
  parameter int unsigned PTRW  = 16,
  localparam int unsigned QIDW = $clog2(NQ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msi_mode,
  input logic             post_hit,
  input logic [QIDW-1:0]  post_qid,
  input logic             db_valid,
  input logic             db_ien,
  input logic [QIDW-1:0]  db_qid,
  input logic [PTRW-1:0]  db_head,
  input logic [PTRW-1:0]  db_tail,
  input logic             mset_hit,
  input logic             mclr_hit,
  input logic [MASKW-1:0] reg_wdata,
  input logic [MASKW-1:0] mask_q,
  input logic [NQ-1:0]    pend_q,
  input logic             irq_pin
);
  logic [NQ-1:0] mask_w;
  always_comb begin
    mask_w = '0;
    mask_w[MASKW-1:0] = mask_q;
  end

  // R2
  pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin == ((pend_q & ~mask_w) != '0));

  // R3
  post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_hit |=> pend_q[$past(post_qid)]);

  // R4
  partial_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && db_ien && !msi_mode && db_head != db_tail && pend_q[db_qid])
      |=> pend_q[$past(db_qid)]);

  // R6
  msi_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_mode |=> ($stable(pend_q) && $stable(mask_q) && $stable(irq_pin)));

  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mset_hit |=> ((mask_q & $past(reg_wdata)) == $past(reg_wdata)));

  // R7
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_hit |=> ((mask_q & $past(reg_wdata)) == '0));
endmodule

bind qia_top qia_chk #(.NQ(NQ), .MASKW(MASKW), .PTRW(PTRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode),
  .post_hit(post_hit), .post_qid(post_qid),
  .db_valid(db_valid), .db_ien(db_ien), .db_qid(db_qid),
  .db_head(db_head), .db_tail(db_tail),
  .mset_hit(mset_hit), .mclr_hit(mclr_hit), .reg_wdata(reg_wdata),
  .mask_q(mask_q), .pend_q(pend_q), .irq_pin(irq_pin)
);

// File: tb/sim_qia_top.sv
`timescale 1ns/1ps
module sim_qia_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_mode = 0, post_valid = 0, post_ien = 0;
  logic [5:0]  post_qid = 0, db_qid = 0;
  logic        db_valid = 0, db_ien = 0;
  logic [15:0] db_head = 0, db_tail = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [63:0] pend_o;
  logic        irq_pin;

  int vectors = 0, miscompares = 0;
  logic [63:0] m_pend = '0;
  logic [31:0] m_mask = '0;
  logic        m_pin  = 1'b0;

  always #10 clk = ~clk;

  qia_top u0 (.*);

  // bench-side restatement: walk the bits
  function automatic logic exp_pin(input logic [63:0] p, input logic [31:0] m);
    for (int i = 0; i < 64; i++)
      if (p[i] && (i >= 32 || !m[i])) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic [31:0] m);
    return (a == 8'h0C || a == 8'h10) ? m : 32'h0;
  endfunction

  task automatic chk1(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s irq_pin act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic chkv(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // advance the model for the inputs currently driven
  task automatic model_edge();
    if (!msi_mode) begin
      if (db_valid && db_ien && db_head == db_tail) m_pend[db_qid] = 1'b0;
      if (post_valid && post_ien) m_pend[post_qid] = 1'b1;
      if (reg_wr && reg_addr == 8'h0C) m_mask = m_mask | reg_wdata;
      if (reg_wr && reg_addr == 8'h10) m_mask = m_mask & ~reg_wdata;
      m_pin = exp_pin(m_pend, m_mask);
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk1(req, irq_pin, m_pin);
    chkv(req, "pend", pend_o, m_pend);
    chkv("R8", "rdata", {32'h0, reg_rdata}, {32'h0, exp_rd(reg_addr, m_mask)});
  endtask

  task automatic idle();
    msi_mode = 0; post_valid = 0; post_ien = 0; db_valid = 0; db_ien = 0;
    reg_wr = 0; reg_addr = 8'h0C; reg_wdata = 0; db_head = 0; db_tail = 0;
  endtask

  task automatic post(input logic [5:0] q, input logic en);
    idle(); post_valid = 1; post_qid = q; post_ien = en;
  endtask

  task automatic dbell(input logic [5:0] q, input logic en, input logic [15:0] h,
                       input logic [15:0] t);
    idle(); db_valid = 1; db_qid = q; db_ien = en; db_head = h; db_tail = t;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    idle(); reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk1("R1", irq_pin, 1'b0);
    chkv("R1", "pend", pend_o, 64'h0);
    chkv("R1", "mask", {32'h0, reg_rdata}, 64'h0);

    // R3 posting raises pin
    post(6'd5, 1); step("R3");
    // R7 mask q5, pin drops one edge later (R2)
    wreg(8'h0C, 32'h0000_0020); step("R2");
    chk1("R2", irq_pin, 1'b0);
    // R8 readback at clear offset and at an unrelated offset
    idle(); reg_addr = 8'h10; #1; chkv("R8", "rdata", {32'h0, reg_rdata}, 64'h20);
    reg_addr = 8'h14; #1; chkv("R8", "rdata", {32'h0, reg_rdata}, 64'h0);
    // R2 high queue cannot be masked
    wreg(8'h0C, 32'hFFFF_FFFF); step("R7");
    post(6'd40, 1); step("R2");
    chk1("R2", irq_pin, 1'b1);
    // R4 partial consume keeps, full consume clears
    dbell(6'd40, 1, 16'd3, 16'd7); step("R4");
    chkv("R4", "pend40", {63'h0, pend_o[40]}, 64'h1);
    dbell(6'd40, 1, 16'd7, 16'd7); step("R4");
    chk1("R4", irq_pin, 1'b0);
    // R5 disabled queue ignored
    post(6'd50, 0); step("R5");
    chk1("R5", irq_pin, 1'b0);
    dbell(6'd5, 0, 16'd1, 16'd1); step("R5");
    chkv("R5", "pend5", {63'h0, pend_o[5]}, 64'h1);
    // R6 frozen in message-signalled mode
    post(6'd60, 1); msi_mode = 1; step("R6");
    chk1("R6", irq_pin, 1'b0);
    wreg(8'h10, 32'hFFFF_FFFF); msi_mode = 1; step("R6");
    chkv("R6", "mask", {32'h0, reg_rdata}, 64'hFFFF_FFFF);
    // R7 unmask q5 -> pin rises without new event on the queue
    wreg(8'h10, 32'h0000_0020); step("R7");
    chk1("R7", irq_pin, 1'b1);
    // R9 set and clear same queue same cycle
    dbell(6'd12, 1, 16'd2, 16'd2); post_valid = 1; post_qid = 6'd12; post_ien = 1;
    step("R9");
    chkv("R9", "pend12", {63'h0, pend_o[12]}, 64'h1);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      idle();
      msi_mode   = ($urandom % 10) == 0;
      post_valid = ($urandom % 3) == 0;
      post_qid   = 6'($urandom);
      post_ien   = ($urandom % 5) != 0;
      db_valid   = ($urandom % 3) == 0;
      db_qid     = ($urandom % 2) ? post_qid : 6'($urandom);
      db_ien     = ($urandom % 5) != 0;
      db_tail    = 16'($urandom % 4);
      db_head    = ($urandom % 2) ? db_tail : 16'($urandom % 4);
      reg_wr     = ($urandom % 4) == 0;
      case ($urandom % 3)
        0: reg_addr = 8'h0C;
        1: reg_addr = 8'h10;
        default: reg_addr = 8'($urandom);
      endcase
      reg_wdata  = $urandom & $urandom;
      step("R2");
    end

    idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule